// File: doc/BRIEF.md
# Control-Transfer Target Address Generator

This block sits beside the instruction decoder of a 16-bit core that uses real-mode segmented addressing. For every unconditional control transfer it works out the code segment and instruction offset that fetch must continue from. The decoder supplies several inputs together with a request pulse:

- the transfer kind,
- the four instruction bytes that follow the opcode,
- the offset of the next sequential instruction,
- the current code segment,
- a general register operand,
- the two words already read from a jump table.

On the clock edge that follows a request, the block presents the new segment and offset together with a one-cycle load strobe.

Each kind is handled in one of four ways:

| Kind | Offset result | Segment result |
|------|---------------|----------------|
| Short relative | next offset + sign-extended 8-bit displacement | unchanged |
| Near relative | next offset + 16-bit displacement | unchanged |
| Register indirect, table near | the supplied word, with no addition | unchanged |
| Immediate far, table far | the supplied offset | the supplied segment |

All offset arithmetic wraps modulo 2^16, so a transfer never leaves the current segment unless it is one of the far kinds. The next-offset input is expected to already account for the instruction length: 2 bytes for short, 3 for near and 5 for far. Reading instruction bytes and reading memory for the tables are handled outside this block.

Top module: `xfer_target_gen`

## Requirements
- R1: Kind code 0 (short): one cycle after the request, `new_ip` equals `next_ip` plus the sign-extended byte `op_bytes[7:0]`, modulo 2^16.
- R2: Kind code 1 (near): one cycle after the request, `new_ip` equals `next_ip` plus `op_bytes[15:0]`, modulo 2^16.
- R3: Kind code 2 (immediate far): one cycle after the request, `new_ip` equals `op_bytes[15:0]` and `new_cs` equals `op_bytes[31:16]`.
- R4: Kind code 3 (register): one cycle after the request, `new_ip` equals `reg_val` exactly, with no addition.
- R5: Kind code 4 (table near): one cycle after the request, `new_ip` equals `tbl_off`.
- R6: Kind code 5 (table far): one cycle after the request, `new_ip` equals `tbl_off` and `new_cs` equals `tbl_seg`.
- R7: For kind codes 0, 1, 3 and 4, `new_cs` equals the `cur_cs` value that was present with the request.
- R8: Every request with a kind code from 0 to 5 raises `load` for exactly the next cycle. Back-to-back requests give a strobe in each cycle, each carrying its own result.
- R9: Kind codes 6 and 7 raise no `load`, and `new_ip` and `new_cs` keep their previous values.
- R10: While `rst_n` is low at a clock edge, `load`, `new_ip` and `new_cs` are cleared to zero.
- R11: In any cycle where `load` is low, `new_ip` and `new_cs` are unchanged from the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A transfer request is present this cycle |
| xfer_kind | input | 3 | Transfer kind code (0 to 5 valid) |
| op_bytes | input | 32 | Bytes following the opcode; byte 2 in [7:0] through byte 5 in [31:24] |
| next_ip | input | 16 | Offset of the next sequential instruction |
| cur_cs | input | 16 | Current code segment |
| reg_val | input | 16 | Register operand for register-indirect transfers |
| tbl_off | input | 16 | Offset word read from the jump table |
| tbl_seg | input | 16 | Segment word read from the jump table |
| new_ip | output | 16 | Target offset |
| new_cs | output | 16 | Target code segment |
| load | output | 1 | One-cycle strobe marking a valid target |

## Verification
A fresh request can be accepted in the same cycle that the result of the previous request is being presented. The register stage therefore has to present one result while capturing the next, and a mistake would let a stale segment or offset leak from one transfer into the following one.

The bench provokes this by holding `req_valid` high through every sweep, changing the kind and operands on each cycle, so consecutive strobes carry unrelated targets. Each presented result is compared against an expected value computed arithmetically in the bench. Idle cycles and unused codes are placed directly after loads to show that the outputs hold.

// File: rtl/xfer_pkg.sv
// Shared kind encoding for the control-transfer target generator.
// Assumes a 3-bit kind field coming from the decoder.
package xfer_pkg;
    typedef enum logic [2:0] {
        XK_SHORT     = 3'd0,
        XK_NEAR      = 3'd1,
        XK_FAR       = 3'd2,
        XK_REG       = 3'd3,
        XK_TBL_NEAR  = 3'd4,
        XK_TBL_FAR   = 3'd5
    } xfer_kind_e;

    // Source of the offset result
    typedef enum logic [1:0] {
        IPS_REL = 2'd0,
        IPS_IMM = 2'd1,
        IPS_REG = 2'd2,
        IPS_TBL = 2'd3
    } ip_src_e;

    // Source of the segment result
    typedef enum logic [1:0] {
        CSS_KEEP = 2'd0,
        CSS_IMM  = 2'd1,
        CSS_TBL  = 2'd2
    } cs_src_e;
endpackage

// File: rtl/xfer_kind_decode.sv
// Turns the raw kind code into datapath selects.
// Assumes codes above the last defined kind are illegal and must not load.
module xfer_kind_decode
    import xfer_pkg::*;
(
    input  logic [2:0] kind,
    output logic       kind_ok,
    output logic       rel_wide,
    output ip_src_e    ip_src,
    output cs_src_e    cs_src
);
    // Map each kind to its offset/segment sources
    always_comb begin
        kind_ok  = 1'b1;
        rel_wide = 1'b0;
        ip_src   = IPS_REL;
        cs_src   = CSS_KEEP;
        case (kind)
            XK_SHORT:    begin end
            XK_NEAR:     rel_wide = 1'b1;
            XK_FAR:      begin ip_src = IPS_IMM; cs_src = CSS_IMM; end
            XK_REG:      ip_src = IPS_REG;
            XK_TBL_NEAR: ip_src = IPS_TBL;
            XK_TBL_FAR:  begin ip_src = IPS_TBL; cs_src = CSS_TBL; end
            default:     kind_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/xfer_rel_adder.sv
// Relative target adder: base plus either a short sign-extended
// displacement or a full-width displacement, wrapping at IP_W bits.
// Assumes SHORT_W <= IP_W.
module xfer_rel_adder #(
    parameter int IP_W    = 16,
    parameter int SHORT_W = 8
) (
    input  logic [IP_W-1:0]    base,
    input  logic [SHORT_W-1:0] disp_short,
    input  logic [IP_W-1:0]    disp_wide,
    input  logic               wide,
    output logic [IP_W-1:0]    sum
);
    localparam int EXT_W = IP_W - SHORT_W;

    logic [IP_W-1:0] short_ext;

    // Sign-extend the short displacement when it is narrower than IP
    generate
        if (EXT_W > 0) begin : g_ext
            assign short_ext = {{EXT_W{disp_short[SHORT_W-1]}}, disp_short};
        end else begin : g_noext
            assign short_ext = disp_short;
        end
    endgenerate

    // Pick the displacement and add it modulo 2^IP_W
    always_comb begin
        sum = base + (wide ? disp_wide : short_ext);
    end
endmodule

// File: rtl/xfer_target_mux.sv
// Final selection of offset and segment from the decoded sources.
// Assumes selects come from xfer_kind_decode.
module xfer_target_mux
    import xfer_pkg::*;
#(
    parameter int IP_W = 16,
    parameter int CS_W = 16
) (
    input  ip_src_e         ip_src,
    input  cs_src_e         cs_src,
    input  logic [IP_W-1:0] rel_ip,
    input  logic [IP_W-1:0] imm_ip,
    input  logic [IP_W-1:0] reg_ip,
    input  logic [IP_W-1:0] tbl_ip,
    input  logic [CS_W-1:0] keep_cs,
    input  logic [CS_W-1:0] imm_cs,
    input  logic [CS_W-1:0] tbl_cs,
    output logic [IP_W-1:0] ip_out,
    output logic [CS_W-1:0] cs_out
);
    // Offset selection
    always_comb begin
        case (ip_src)
            IPS_REL: ip_out = rel_ip;
            IPS_IMM: ip_out = imm_ip;
            IPS_REG: ip_out = reg_ip;
            default: ip_out = tbl_ip;
        endcase
    end

    // Segment selection
    always_comb begin
        case (cs_src)
            CSS_IMM: cs_out = imm_cs;
            CSS_TBL: cs_out = tbl_cs;
            default: cs_out = keep_cs;
        endcase
    end
endmodule

// File: rtl/xfer_target_gen.sv
// Top of the control-transfer target generator. Computes the next
// segment and offset for a request and registers them with a load strobe.
// Assumes next_ip already includes the instruction length and that the
// table words are valid in the request cycle.
module xfer_target_gen
    import xfer_pkg::*;
#(
    parameter int IP_W    = 16,
    parameter int CS_W    = 16,
    parameter int SHORT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           xfer_kind,
    input  logic [IP_W+CS_W-1:0] op_bytes,
    input  logic [IP_W-1:0]      next_ip,
    input  logic [CS_W-1:0]      cur_cs,
    input  logic [IP_W-1:0]      reg_val,
    input  logic [IP_W-1:0]      tbl_off,
    input  logic [CS_W-1:0]      tbl_seg,
    output logic [IP_W-1:0]      new_ip,
    output logic [CS_W-1:0]      new_cs,
    output logic                 load
);
    localparam int SEG_LSB = IP_W;

    logic            kind_ok;
    logic            rel_wide;
    ip_src_e         ip_src;
    cs_src_e         cs_src;
    logic [IP_W-1:0] rel_ip;
    logic [IP_W-1:0] ip_nxt;
    logic [CS_W-1:0] cs_nxt;

    xfer_kind_decode u_dec (
        .kind     (xfer_kind),
        .kind_ok  (kind_ok),
        .rel_wide (rel_wide),
        .ip_src   (ip_src),
        .cs_src   (cs_src)
    );

    xfer_rel_adder #(.IP_W(IP_W), .SHORT_W(SHORT_W)) u_add (
        .base       (next_ip),
        .disp_short (op_bytes[SHORT_W-1:0]),
        .disp_wide  (op_bytes[IP_W-1:0]),
        .wide       (rel_wide),
        .sum        (rel_ip)
    );

    xfer_target_mux #(.IP_W(IP_W), .CS_W(CS_W)) u_mux (
        .ip_src  (ip_src),
        .cs_src  (cs_src),
        .rel_ip  (rel_ip),
        .imm_ip  (op_bytes[IP_W-1:0]),
        .reg_ip  (reg_val),
        .tbl_ip  (tbl_off),
        .keep_cs (cur_cs),
        .imm_cs  (op_bytes[SEG_LSB+CS_W-1:SEG_LSB]),
        .tbl_cs  (tbl_seg),
        .ip_out  (ip_nxt),
        .cs_out  (cs_nxt)
    );

    // Result register: capture target on an accepted request, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_ip <= '0;
            new_cs <= '0;
            load   <= 1'b0;
        end else begin
            load <= req_valid && kind_ok;
            if (req_valid && kind_ok) begin
                new_ip <= ip_nxt;
                new_cs <= cs_nxt;
            end
        end
    end
endmodule

// File: rtl/xfer_target_gen_chk.sv
// Property checker for xfer_target_gen, attached by bind.
// Assumes default widths: 16-bit offset and segment.
module xfer_target_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  xfer_kind,
    input logic [31:0] op_bytes,
    input logic [15:0] next_ip,
    input logic [15:0] cur_cs,
    input logic [15:0] reg_val,
    input logic [15:0] tbl_off,
    input logic [15:0] tbl_seg,
    input logic [15:0] new_ip,
    input logic [15:0] new_cs,
    input logic        load
);
    logic armed;

    // Marks that one clean cycle out of reset has passed
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R8
    strobe_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (req_valid && xfer_kind <= 3'd5) |=> load);

    // R9
    unused_kind_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (!req_valid || xfer_kind > 3'd5) |=> !load);

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !load |-> ($stable(new_ip) && $stable(new_cs)));

    // R7
    intra_keeps_cs_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (req_valid && (xfer_kind == 3'd0 || xfer_kind == 3'd1 ||
                       xfer_kind == 3'd3 || xfer_kind == 3'd4))
        |=> (new_cs == $past(cur_cs)));

    // R3
    far_imm_target_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (req_valid && xfer_kind == 3'd2)
        |=> (new_ip == $past(op_bytes[15:0]) && new_cs == $past(op_bytes[31:16])));

    // R4
    reg_direct_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (req_valid && xfer_kind == 3'd3) |=> (new_ip == $past(reg_val)));

    // R6
    tbl_far_target_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (req_valid && xfer_kind == 3'd5)
        |=> (new_ip == $past(tbl_off) && new_cs == $past(tbl_seg)));
endmodule

bind xfer_target_gen xfer_target_gen_chk u_chk (.*);

// File: tb/xfer_target_gen_bench.sv
module xfer_target_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  xfer_kind = 3'd0;
    logic [31:0] op_bytes = '0;
    logic [15:0] next_ip = '0;
    logic [15:0] cur_cs = '0;
    logic [15:0] reg_val = '0;
    logic [15:0] tbl_off = '0;
    logic [15:0] tbl_seg = '0;
    logic [15:0] new_ip;
    logic [15:0] new_cs;
    logic        load;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_ip = '0;
    logic [15:0] exp_cs = '0;

    always #4 clk = ~clk;

    xfer_target_gen u_xfer_target_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .xfer_kind(xfer_kind),
        .op_bytes(op_bytes), .next_ip(next_ip), .cur_cs(cur_cs), .reg_val(reg_val),
        .tbl_off(tbl_off), .tbl_seg(tbl_seg),
        .new_ip(new_ip), .new_cs(new_cs), .load(load)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request at a negedge; check the registered result one cycle later
    task automatic request(input logic [2:0] k, input logic [31:0] ob, input logic [15:0] nip,
                           input logic [15:0] ccs, input logic [15:0] rv,
                           input logic [15:0] toff, input logic [15:0] tseg,
                           input string req);
        logic exp_ld;
        req_valid = 1'b1; xfer_kind = k; op_bytes = ob; next_ip = nip;
        cur_cs = ccs; reg_val = rv; tbl_off = toff; tbl_seg = tseg;
        exp_ld = 1'b1;
        case (k)
            3'd0: begin exp_ip = nip + {{8{ob[7]}}, ob[7:0]}; exp_cs = ccs; end
            3'd1: begin exp_ip = nip + ob[15:0]; exp_cs = ccs; end
            3'd2: begin exp_ip = ob[15:0]; exp_cs = ob[31:16]; end
            3'd3: begin exp_ip = rv; exp_cs = ccs; end
            3'd4: begin exp_ip = toff; exp_cs = ccs; end
            3'd5: begin exp_ip = toff; exp_cs = tseg; end
            default: exp_ld = 1'b0;
        endcase
        @(negedge clk);
        check({req, " R8 strobe"}, {47'd0, load}, {47'd0, exp_ld});
        check(req, {load, new_cs, new_ip}, {exp_ld, exp_cs, exp_ip});
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
        check("R11 hold", {load, new_cs, new_ip}, {1'b0, exp_cs, exp_ip});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [15:0] nips [4];
        nips[0] = 16'h0000; nips[1] = 16'h7FFE; nips[2] = 16'hFFF8; nips[3] = 16'h1234;
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R10 reset state
        check("R10 reset", {load, new_cs, new_ip}, 48'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", {load, new_cs, new_ip}, 48'd0);

        // R1 short: all displacement bytes against wrap-prone bases
        for (int n = 0; n < 4; n++)
            for (int d = 0; d < 256; d++)
                request(3'd0, {24'hA5C3_00 ^ 24'(d * 7), 8'(d)}, nips[n], 16'h2000 + 16'(d),
                        16'hDEAD, 16'hBEEF, 16'hCAFE, "R1 short / R7 cs");
        idle();

        // R2 near: spread of 16-bit displacements including wrap
        for (int n = 0; n < 4; n++)
            for (int i = 0; i < 128; i++)
                request(3'd1, {16'h5A5A, 16'(i * 517) ^ 16'(i << 9)}, nips[n], 16'h0F00 ^ 16'(i),
                        16'h1111, 16'h2222, 16'h3333, "R2 near / R7 cs");
        request(3'd1, 32'h0000_8000, 16'h8000, 16'h0001, 0, 0, 0, "R2 near wrap to 0");

        // R3 far immediate
        for (int i = 0; i < 128; i++)
            request(3'd2, {16'(i * 911), 16'(i * 263 + 5)}, 16'(i), 16'h4444,
                    16'h0, 16'h0, 16'h0, "R3 far");

        // R4 register, R5 table near, R6 table far, interleaved back-to-back
        for (int i = 0; i < 128; i++) begin
            request(3'd3, 32'hFFFF_FFFF, 16'h1000, 16'(i * 3), 16'(i * 401 + 1),
                    16'h7777, 16'h8888, "R4 reg / R7 cs");
            request(3'd4, 32'h1234_5678, 16'h2000, 16'h0ACE, 16'h9999,
                    16'(i * 613), 16'h5555, "R5 tbl near / R7 cs");
            request(3'd5, 32'h0, 16'h3000, 16'h0BAD, 16'hAAAA,
                    16'(i * 97 + 3), 16'(i * 1301), "R6 tbl far");
        end
        idle();

        // R9 unused codes directly after a load, and repeated
        request(3'd2, 32'hF00D_0042, 16'h0, 16'h0, 0, 0, 0, "R3 far before unused");
        for (int k = 6; k < 8; k++)
            for (int i = 0; i < 8; i++)
                request(3'(k), 32'h1357_9BDF, 16'(i), 16'hFFFF, 16'h0123,
                        16'h4567, 16'h89AB, "R9 unused code");
        idle();
        idle();

        // R10 reset in mid-operation
        request(3'd5, 0, 0, 0, 0, 16'hCCCC, 16'hDDDD, "R6 before reset");
        rst_n = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        exp_ip = '0; exp_cs = '0;
        check("R10 reset with request", {load, new_cs, new_ip}, 48'd0);
        rst_n = 1'b1; req_valid = 1'b0;
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule